// File: doc/BRIEF.md
# Load/Use Interlock for a Forwarding-Free Five-Stage Pipeline

This block decides, every cycle, whether the instruction sitting in the decode stage may advance. The pipeline has no bypass network, so a consumer must wait until its producer has reached write-back. The register file writes in the first half of a cycle and reads in the second half, so a producer in write-back is already visible. The only conflicts are with instructions in the execute and memory stages.

The block is purely combinational. It takes the decode-stage instruction word and its operation class. It also takes the destination register and write-enable held in the two downstream pipeline registers. From these it drives three controls: the program-counter write enable, the fetch/decode register write enable, and the select of the mux that turns the control bits entering execute into a bubble. The surrounding pipeline applies these controls on its next clock edge. A consumer placed directly behind its producer is therefore held for two cycles, one placed two slots behind for one cycle, and one placed three or more slots behind is not held.

Top module: `hazard_stall_unit`

## Requirements
- R1: With no dependence, pc_write_en=1, ifid_write_en=1 and bubble_sel=0.
- R2: When the first source (instruction bits 9:5) is read and equals ex_dst while ex_reg_write=1, all three controls switch to stall (pc_write_en=0, ifid_write_en=0, bubble_sel=1).
- R3: The same comparison against mem_dst gated by mem_reg_write also stalls.
- R4: The second source is bits 20:16 when instruction bit 28 is 0 and bits 4:0 when bit 28 is 1. A match on the field that is not selected never stalls.
- R5: Operation classes, coded on id_class, are 0 none, 1 register arithmetic, 2 immediate shift, 3 immediate arithmetic, 4 load, 5 store, 6 conditional branch, 7 unconditional branch. Classes 1 and 5 read both sources. Classes 2, 3 and 4 read only the first source. Class 6 reads only the second. Classes 0 and 7 read none. An unread source never stalls.
- R6: A stage whose write-enable is 0 (a bubble, a store or a branch) never causes a stall.
- R7: Register 31 never creates a dependence.
- R8: In a pipeline that applies the controls, a consumer 1, 2 or 3 slots behind its producer is held 2, 1 or 0 cycles. Back-to-back producers feeding one consumer give 2 cycles.
- R9: The three controls always agree: pc_write_en equals ifid_write_en, and bubble_sel is their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in decode |
| id_class | input | 3 | Operation class of the decode instruction |
| ex_dst | input | 5 | Destination register held for the execute stage |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination register held for the memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may load |
| bubble_sel | output | 1 | Zero the control bits entering execute |

## Verification
Directed vectors place one matching register in each source field against each stage, one at a time. This separates a real hit from a match in a field that is unselected or unread. Random vectors draw registers from a small pool plus register 31, so that hits, double hits, gated-off stages and zero-register cases all occur often. A cycle model of the pipeline runs short programs and counts the hold cycles of each consumer. This tells apart producer distances of one, two and three slots, back-to-back producers, and non-writing producers.

// File: rtl/hsu_pkg.sv
// Shared types of the interlock: operation classes seen in decode.
package hsu_pkg;
    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        OPC_NONE   = 3'd0,
        OPC_ARITH  = 3'd1,
        OPC_SHIFT  = 3'd2,
        OPC_IMM    = 3'd3,
        OPC_LOAD   = 3'd4,
        OPC_STORE  = 3'd5,
        OPC_CONDBR = 3'd6,
        OPC_BRANCH = 3'd7
    } op_class_e;
endpackage

// File: rtl/hsu_operand_sel.sv
// Extracts the two source register numbers of the decode instruction and
// flags which of them the instruction actually reads.
// Assumes: bit FMT_BIT set selects the low field as second source.
module hsu_operand_sel
    import hsu_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int RA_W    = 5,
    parameter int RN_LSB  = 5,
    parameter int RM_LSB  = 16,
    parameter int RT_LSB  = 0,
    parameter int FMT_BIT = 28
) (
    input  logic [INSTR_W-1:0] instr,
    input  op_class_e          cls,
    output logic [RA_W-1:0]    src_a,
    output logic [RA_W-1:0]    src_b,
    output logic               use_a,
    output logic               use_b
);
    logic unused_instr_bits;
    assign unused_instr_bits = ^instr;

    // Field extraction, second source chosen by the format bit.
    always_comb begin
        src_a = instr[RN_LSB +: RA_W];
        src_b = instr[FMT_BIT] ? instr[RT_LSB +: RA_W] : instr[RM_LSB +: RA_W];
    end

    // Which sources each class reads.
    always_comb begin
        unique case (cls)
            OPC_ARITH, OPC_STORE:           begin use_a = 1'b1; use_b = 1'b1; end
            OPC_SHIFT, OPC_IMM, OPC_LOAD:   begin use_a = 1'b1; use_b = 1'b0; end
            OPC_CONDBR:                     begin use_a = 1'b0; use_b = 1'b1; end
            default:                        begin use_a = 1'b0; use_b = 1'b0; end
        endcase
    end
endmodule

// File: rtl/hsu_dep_match.sv
// One source-versus-destination comparator.
// Assumes: register ZERO_REG is hard-wired and never carries a value.
module hsu_dep_match #(
    parameter int RA_W     = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [RA_W-1:0] src,
    input  logic            src_used,
    input  logic [RA_W-1:0] dst,
    input  logic            dst_written,
    output logic            hit
);
    // Hit only for a real, read source against a real, written destination.
    always_comb begin
        hit = src_used && dst_written && (src == dst) && (dst != RA_W'(ZERO_REG));
    end
endmodule

// File: rtl/hsu_stall_ctrl.sv
// Turns the collected hit vector into the three pipeline controls.
module hsu_stall_ctrl #(
    parameter int N_HITS = 4
) (
    input  logic [N_HITS-1:0] hits,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble
);
    // Any hit freezes fetch and decode and injects a bubble.
    always_comb begin
        bubble  = |hits;
        pc_we   = ~bubble;
        ifid_we = ~bubble;
    end
endmodule

// File: rtl/hazard_stall_unit.sv
// Interlock for a pipeline without bypassing: holds the decode
// instruction while any read source is still owed by the execute or
// memory stage. Assumes write-back writes before decode reads.
module hazard_stall_unit
    import hsu_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int RA_W     = 5,
    parameter int RN_LSB   = 5,
    parameter int RM_LSB   = 16,
    parameter int RT_LSB   = 0,
    parameter int FMT_BIT  = 28,
    parameter int ZERO_REG = 31
) (
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [CLASS_W-1:0] id_class,
    input  logic [RA_W-1:0]    ex_dst,
    input  logic               ex_reg_write,
    input  logic [RA_W-1:0]    mem_dst,
    input  logic               mem_reg_write,
    output logic               pc_write_en,
    output logic               ifid_write_en,
    output logic               bubble_sel
);
    localparam int N_PROD = 2;
    localparam int N_SRC  = 2;
    localparam int N_HITS = N_PROD * N_SRC;

    logic [RA_W-1:0]   src   [N_SRC];
    logic [N_SRC-1:0]  used;
    logic [RA_W-1:0]   pdst  [N_PROD];
    logic [N_PROD-1:0] pwr;
    logic [N_HITS-1:0] hits;

    hsu_operand_sel #(
        .INSTR_W(INSTR_W), .RA_W(RA_W), .RN_LSB(RN_LSB),
        .RM_LSB(RM_LSB), .RT_LSB(RT_LSB), .FMT_BIT(FMT_BIT)
    ) u_sel (
        .instr (id_instr),
        .cls   (op_class_e'(id_class)),
        .src_a (src[0]),
        .src_b (src[1]),
        .use_a (used[0]),
        .use_b (used[1])
    );

    // Gather downstream producers into an indexable list.
    always_comb begin
        pdst[0] = ex_dst;
        pwr[0]  = ex_reg_write;
        pdst[1] = mem_dst;
        pwr[1]  = mem_reg_write;
    end

    for (genvar p = 0; p < N_PROD; p++) begin : g_prod
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            hsu_dep_match #(.RA_W(RA_W), .ZERO_REG(ZERO_REG)) u_cmp (
                .src         (src[s]),
                .src_used    (used[s]),
                .dst         (pdst[p]),
                .dst_written (pwr[p]),
                .hit         (hits[p*N_SRC + s])
            );
        end
    end

    hsu_stall_ctrl #(.N_HITS(N_HITS)) u_ctrl (
        .hits    (hits),
        .pc_we   (pc_write_en),
        .ifid_we (ifid_write_en),
        .bubble  (bubble_sel)
    );
endmodule

// File: rtl/hazard_stall_unit_chk.sv
// Port-level checks of the interlock, bound into every instance.
module hazard_stall_unit_chk #(
    parameter int INSTR_W  = 32,
    parameter int RA_W     = 5,
    parameter int RN_LSB   = 5,
    parameter int FMT_BIT  = 28,
    parameter int ZERO_REG = 31
) (
    input logic [INSTR_W-1:0] id_instr,
    input logic [2:0]         id_class,
    input logic [RA_W-1:0]    ex_dst,
    input logic               ex_reg_write,
    input logic [RA_W-1:0]    mem_dst,
    input logic               mem_reg_write,
    input logic               pc_write_en,
    input logic               ifid_write_en,
    input logic               bubble_sel
);
    logic reads_a;
    logic [RA_W-1:0] rn;
    assign reads_a = (id_class inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5});
    assign rn      = id_instr[RN_LSB +: RA_W];

    // Relations between inputs and the three controls.
    always_comb begin
        a_r9_controls_agree: assert ((pc_write_en == ifid_write_en) && (bubble_sel == !pc_write_en))
            else $error("R9 controls disagree");
        a_r6_no_writer_no_stall: assert (ex_reg_write || mem_reg_write || !bubble_sel)
            else $error("R6 stall without writer");
        a_r7_zero_reg_free: assert (!((ex_dst == RA_W'(ZERO_REG)) && (mem_dst == RA_W'(ZERO_REG))) || !bubble_sel)
            else $error("R7 stall on zero register");
        a_r5_no_reads_no_stall: assert (!(id_class inside {3'd0, 3'd7}) || !bubble_sel)
            else $error("R5 stall on class without sources");
        a_r2_ex_first_source: assert (!(reads_a && ex_reg_write && rn == ex_dst && ex_dst != RA_W'(ZERO_REG)) || bubble_sel)
            else $error("R2 missed execute-stage hit");
        a_r3_mem_first_source: assert (!(reads_a && mem_reg_write && rn == mem_dst && mem_dst != RA_W'(ZERO_REG)) || bubble_sel)
            else $error("R3 missed memory-stage hit");
    end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(
    .INSTR_W(INSTR_W), .RA_W(RA_W), .RN_LSB(RN_LSB),
    .FMT_BIT(FMT_BIT), .ZERO_REG(ZERO_REG)
) u_chk (.*);

// File: tb/hazard_stall_unit_tb.sv
module hazard_stall_unit_tb;
    logic        clk = 1'b0;
    logic [31:0] id_instr;
    logic [2:0]  id_class;
    logic [4:0]  ex_dst, mem_dst;
    logic        ex_reg_write, mem_reg_write;
    logic        pc_write_en, ifid_write_en, bubble_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hazard_stall_unit u_dut (
        .id_instr(id_instr), .id_class(id_class),
        .ex_dst(ex_dst), .ex_reg_write(ex_reg_write),
        .mem_dst(mem_dst), .mem_reg_write(mem_reg_write),
        .pc_write_en(pc_write_en), .ifid_write_en(ifid_write_en),
        .bubble_sel(bubble_sel)
    );

    // Instruction word: bit 28 format, [20:16] Rm, [9:5] Rn, [4:0] Rt/Rd.
    function automatic logic [31:0] enc(input logic b28, input logic [4:0] rm,
                                        input logic [4:0] rn, input logic [4:0] rt);
        logic [31:0] w = '0;
        w[28] = b28; w[20:16] = rm; w[9:5] = rn; w[4:0] = rt;
        return w;
    endfunction

    function automatic bit hit(input logic [4:0] s, input logic [4:0] d, input logic w);
        return w && (d != 5'd31) && (s == d);
    endfunction

    // Expected stall from R2..R7.
    function automatic bit exp_stall(input logic [31:0] ins, input logic [2:0] c,
                                     input logic [4:0] ed, input logic ew,
                                     input logic [4:0] md, input logic mw);
        bit ua = (c == 1 || c == 2 || c == 3 || c == 4 || c == 5);
        bit ub = (c == 1 || c == 5 || c == 6);
        logic [4:0] a = ins[9:5];
        logic [4:0] b = ins[28] ? ins[4:0] : ins[20:16];
        return (ua && (hit(a, ed, ew) || hit(a, md, mw))) ||
               (ub && (hit(b, ed, ew) || hit(b, md, mw)));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [31:0] ins, input logic [2:0] c,
                                   input logic [4:0] ed, input logic ew,
                                   input logic [4:0] md, input logic mw, input string req);
        bit e;
        @(negedge clk);
        id_instr = ins; id_class = c; ex_dst = ed; ex_reg_write = ew;
        mem_dst = md; mem_reg_write = mw;
        #2;
        e = exp_stall(ins, c, ed, ew, md, mw);
        check(bubble_sel == e, req, int'(bubble_sel), int'(e));
        check(pc_write_en == !e && ifid_write_en == !e, {req, "/R9"},
              int'({pc_write_en, ifid_write_en}), e ? 0 : 3);
    endtask

    // Program for the cycle model.
    logic [31:0] s_ins [8];
    logic [2:0]  s_cls [8];
    logic [4:0]  s_rd  [8];
    logic        s_wr  [8];
    int          s_exp [8];

    task automatic set_slot(input int i, input logic [2:0] c, input logic [31:0] ins,
                            input logic [4:0] rd, input logic wr, input int ex);
        s_cls[i] = c; s_ins[i] = ins; s_rd[i] = rd; s_wr[i] = wr; s_exp[i] = ex;
    endtask

    // Cycle model: the pipeline advances by the unit's controls.
    task automatic run_prog(input int n, input string name);
        int pc = 0;
        int held [8];
        logic [4:0] e_d = '0, m_d = '0;
        logic e_w = 1'b0, m_w = 1'b0;
        bit st;
        for (int i = 0; i < 8; i++) held[i] = 0;
        for (int cyc = 0; cyc < 40 && pc < n; cyc++) begin
            @(negedge clk);
            id_instr = s_ins[pc]; id_class = s_cls[pc];
            ex_dst = e_d; ex_reg_write = e_w; mem_dst = m_d; mem_reg_write = m_w;
            #2;
            st = bubble_sel;
            if (st) held[pc]++;
            @(posedge clk);
            m_d = e_d; m_w = e_w;
            if (st) begin
                e_w = 1'b0; e_d = '0;
            end else begin
                e_d = s_rd[pc]; e_w = s_wr[pc]; pc++;
            end
        end
        for (int i = 0; i < n; i++)
            check(held[i] == s_exp[i], {"R8 ", name}, held[i], s_exp[i]);
    endtask

    function automatic logic [4:0] pick_reg();
        int r = $urandom % 6;
        return (r == 5) ? 5'd31 : 5'(r);
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        id_instr = '0; id_class = 3'd0; ex_dst = '0; mem_dst = '0;
        ex_reg_write = 1'b0; mem_reg_write = 1'b0;

        // R1: idle inputs, no dependence.
        @(negedge clk); #2;
        check(pc_write_en && ifid_write_en && !bubble_sel, "R1 idle", int'(bubble_sel), 0);
        apply_and_check(enc(0, 5'd1, 5'd2, 5'd3), 3'd1, 5'd7, 1, 5'd8, 1, "R1 no match");

        // R2, R3: first source against each stage.
        apply_and_check(enc(0, 5'd1, 5'd5, 5'd3), 3'd1, 5'd5, 1, 5'd8, 1, "R2 ex rn");
        apply_and_check(enc(1, 5'd1, 5'd5, 5'd3), 3'd4, 5'd9, 1, 5'd5, 1, "R3 mem rn");

        // R4: format bit chooses the second source.
        apply_and_check(enc(0, 5'd6, 5'd2, 5'd7), 3'd1, 5'd6, 1, 5'd0, 0, "R4 rm chosen");
        apply_and_check(enc(0, 5'd6, 5'd2, 5'd7), 3'd1, 5'd7, 1, 5'd0, 0, "R4 rt ignored");
        apply_and_check(enc(1, 5'd6, 5'd2, 5'd7), 3'd5, 5'd7, 1, 5'd0, 0, "R4 rt chosen");
        apply_and_check(enc(1, 5'd6, 5'd2, 5'd7), 3'd5, 5'd6, 1, 5'd0, 0, "R4 rm ignored");

        // R5: class decides which sources are read.
        apply_and_check(enc(0, 5'd6, 5'd2, 5'd7), 3'd2, 5'd6, 1, 5'd6, 1, "R5 shift no rm");
        apply_and_check(enc(1, 5'd6, 5'd2, 5'd7), 3'd6, 5'd2, 1, 5'd2, 1, "R5 cbr no rn");
        apply_and_check(enc(1, 5'd6, 5'd2, 5'd7), 3'd6, 5'd7, 1, 5'd0, 0, "R5 cbr rt");
        apply_and_check(enc(1, 5'd6, 5'd2, 5'd7), 3'd7, 5'd2, 1, 5'd7, 1, "R5 branch none");

        // R6, R7: gating and zero register.
        apply_and_check(enc(0, 5'd6, 5'd2, 5'd7), 3'd1, 5'd2, 0, 5'd6, 0, "R6 gated");
        apply_and_check(enc(0, 5'd31, 5'd31, 5'd7), 3'd1, 5'd31, 1, 5'd31, 1, "R7 zero reg");

        // Random mix against the expectation function.
        for (int k = 0; k < 400; k++) begin
            apply_and_check(enc(1'($urandom), pick_reg(), pick_reg(), pick_reg()),
                            3'($urandom), pick_reg(), 1'($urandom),
                            pick_reg(), 1'($urandom), "R2/R3/R4/R5/R6/R7 random");
        end

        // R8: hold schedules from the cycle model.
        set_slot(0, 3'd1, enc(0, 5'd1, 5'd2, 5'd5), 5'd5, 1, 0);
        set_slot(1, 3'd4, enc(1, 5'd0, 5'd5, 5'd3), 5'd3, 1, 2);
        run_prog(2, "adjacent");

        set_slot(1, 3'd1, enc(0, 5'd11, 5'd10, 5'd9), 5'd9, 1, 0);
        set_slot(2, 3'd4, enc(1, 5'd0, 5'd5, 5'd3), 5'd3, 1, 1);
        run_prog(3, "two ahead");

        set_slot(2, 3'd1, enc(0, 5'd14, 5'd13, 5'd12), 5'd12, 1, 0);
        set_slot(3, 3'd4, enc(1, 5'd0, 5'd5, 5'd3), 5'd3, 1, 0);
        run_prog(4, "three ahead");

        set_slot(1, 3'd1, enc(0, 5'd8, 5'd7, 5'd6), 5'd6, 1, 0);
        set_slot(2, 3'd1, enc(0, 5'd6, 5'd5, 5'd7), 5'd7, 1, 2);
        run_prog(3, "back to back");

        set_slot(1, 3'd4, enc(1, 5'd0, 5'd5, 5'd3), 5'd3, 1, 2);
        set_slot(2, 3'd1, enc(0, 5'd3, 5'd3, 5'd4), 5'd4, 1, 2);
        run_prog(3, "chain");

        set_slot(0, 3'd5, enc(1, 5'd0, 5'd5, 5'd3), 5'd0, 0, 0);
        set_slot(1, 3'd1, enc(0, 5'd5, 5'd3, 5'd6), 5'd6, 1, 0);
        run_prog(2, "store no producer R6");

        set_slot(0, 3'd1, enc(0, 5'd1, 5'd2, 5'd31), 5'd31, 1, 0);
        set_slot(1, 3'd1, enc(0, 5'd31, 5'd31, 5'd6), 5'd6, 1, 0);
        run_prog(2, "zero register R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule